// File: doc/BRIEF.md
# Serial Flash Command Master

This block is a register-driven serial master for SPI flash memories. Software programs it over a simple 32-bit word bus and it clocks bytes out to one of several flash banks. The serial clock idles high, and every bit is launched on a falling edge and sampled by both sides on the following rising edge. This is SPI clock mode 3, and no other mode exists. The serial clock is the system clock divided by a fixed even ratio, which is 4 by default.

Software writes up to four outgoing bytes into the transmit data word. It then writes a command word that holds a transmit byte count, a receive byte count, a bank number and a go bit. The master asserts the selected chip select and shifts out the transmit bytes. It then clocks in the receive bytes while holding its output low. It releases the chip select and raises a completion flag. Two one-shot trigger bits run a flash status read or a write-enable command without any data loading. The status read places the returned flash status byte in the status word.

The block holds a flag for software-driven command mode, and that flag gates the general go bit. It also holds a write-burst flag that is stored only. The completion flag is cleared by writing a status word whose flag bit is zero.

Top module: `sflash_cmd_master`

## Requirements
- R1: After reset, the words at offsets 0x00, 0x04, 0x08, 0x0C and 0x10 all read zero. The serial clock is high, every chip select output is high and the data output is low.
- R2: The serial clock toggles only while a chip select is low. Each bit keeps the clock low for half the divide ratio and high for the other half. The data output changes only where the clock falls, and each transfer gives exactly 8 rising edges per byte sent plus received.
- R3: The transmit count is bits [2:0] of the command word at 0x04. A count of 0 acts as 1, and a count above 4 acts as 4. Bytes leave the transmit word (0x0C) lowest byte first, and each byte goes most significant bit first.
- R4: The receive count is bits [6:4] of the command word, and a count above 4 acts as 4. Received bytes fill the receive word (0x10) from bit 0 upward in arrival order, with each byte taken most significant bit first. Unfilled bytes read zero, and the data output stays low during the receive phase.
- R5: Go bit 7 of the command word starts a transfer only while bit 28 of the mode word (0x00) is set. Otherwise no clock edge is produced and the completion flag stays clear.
- R6: Bits 28 (software command mode) and 29 (write-burst flag) of the mode word are stored and read back. All other bits of that word read zero.
- R7: Command bit 10 sends byte 0x05 and then receives one byte into bits [7:0] of the status word (0x08). This leaves the receive word unchanged.
- R8: Command bit 11 sends the single byte 0x06 with no receive phase, which gives exactly 8 clock periods.
- R9: When several trigger bits are set in one write, bit 10 wins over bit 11, and bit 11 wins over bit 7. Exactly one transfer runs.
- R10: Command bits [13:12] pick the bank, and only chip select output number bank goes low during the transfer. At no time is more than one chip select low.
- R11: Status bit 8 (completion flag) sets on the same clock edge that releases the chip select. That edge comes one system clock after the last clock-high half ends. Writing the status word with bit 8 at zero clears the flag, and writing it with bit 8 at one leaves it unchanged.
- R12: A command-word write that arrives while a transfer is pending or running is ignored. It changes neither the stored fields nor the traffic, and it starts no later transfer. The command word reads back only its count and bank fields, and the trigger bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Byte offset of the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 4 | Active-low chip select, one per bank |

## Verification
The hardest case to reach from the ports is a command-word write that lands in the middle of a running transfer. It is only visible if the ignored write leaves no trace afterwards, neither in the stored fields nor as a second burst of clock edges. The bench starts a transfer and waits about twenty cycles, so that the engine is surely shifting. It then writes a conflicting command word with a different bank, different counts and the go bit set. After completion it checks the readback, the bank that was used and the edge count, and then watches for another hundred cycles to confirm that no extra edges appear. A behavioural flash model counts the clock edges, records the chip selects and returns known bytes, so that byte order and receive packing are checked bit by bit.

// File: rtl/sfc_pkg.sv
// Package sfc_pkg: register offsets, bit positions, opcodes and helpers shared
// by the serial flash command master. Assumes a 32-bit word bus.
package sfc_pkg;

    // Register offsets (byte addresses)
    localparam int OFS_MODE = 'h00;
    localparam int OFS_CMD  = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_TXD  = 'h0C;
    localparam int OFS_RXD  = 'h10;

    // Mode word bits
    localparam int B_SWCMD = 28;
    localparam int B_BURST = 29;

    // Command word fields
    localparam int F_TXN   = 0;
    localparam int F_RXN   = 4;
    localparam int B_GO    = 7;
    localparam int B_RDSR  = 10;
    localparam int B_WREN  = 11;
    localparam int F_BANK  = 12;

    // Status word bits
    localparam int B_DONE  = 8;

    // Flash opcodes issued by the one-shot triggers
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WREN = 8'h06;

    typedef enum logic [1:0] {
        XOP_NONE = 2'd0,
        XOP_SEND = 2'd1,
        XOP_RDSR = 2'd2,
        XOP_WREN = 2'd3
    } xop_e;

    // Clamp a byte count into [lo, hi]
    function automatic logic [2:0] clamp_cnt(input logic [2:0] n,
                                             input logic [2:0] lo,
                                             input logic [2:0] hi);
        if (n < lo) return lo;
        if (n > hi) return hi;
        return n;
    endfunction

endpackage

// File: rtl/sfc_regs.sv
// Module sfc_regs: register file and command launcher. Decodes bus writes,
// picks the operation from the trigger bits (status read > write enable >
// go), freezes the command word while the engine is busy, and records the
// results the engine hands back. Assumes reads are combinational.
module sfc_regs
    import sfc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_busy_i,
    input  logic              eng_done_i,
    input  logic [DATA_W-1:0] eng_rx_i,
    output logic              start_o,
    output logic [2:0]        tx_bytes_o,
    output logic [2:0]        rx_bytes_o,
    output logic [DATA_W-1:0] tx_word_o,
    output logic [1:0]        bank_o,
    output logic              done_flag_o,
    output logic [15:0]       cmd_view_o
);
    localparam int MAX_BYTES = DATA_W / 8;
    localparam logic [2:0] MAXB = 3'(MAX_BYTES);

    logic              swcmd_q, burst_q;
    logic [2:0]        txn_q, rxn_q;
    logic [1:0]        bank_q;
    logic              done_q;
    logic [7:0]        fstat_q;
    logic [DATA_W-1:0] txd_q, rxd_q;
    logic              start_q;
    logic [2:0]        xtx_q, xrx_q;
    logic [DATA_W-1:0] xword_q;
    xop_e              xop_q;

    logic wr_mode, wr_cmd, wr_stat, wr_txd, cmd_open;

    assign wr_mode  = bus_we && (bus_addr == ADDR_W'(OFS_MODE));
    assign wr_cmd   = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
    assign wr_stat  = bus_we && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_txd   = bus_we && (bus_addr == ADDR_W'(OFS_TXD));
    assign cmd_open = !eng_busy_i && !start_q;

    // Mode word: stores the software-command and write-burst flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swcmd_q <= 1'b0;
            burst_q <= 1'b0;
        end else if (wr_mode) begin
            swcmd_q <= bus_wdata[B_SWCMD];
            burst_q <= bus_wdata[B_BURST];
        end
    end

    // Transmit data word: writable at any time, sampled at launch
    always_ff @(posedge clk) begin
        if (!rst_n) txd_q <= '0;
        else if (wr_txd) txd_q <= bus_wdata;
    end

    // Command word: stores fields and launches at most one operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_q   <= '0;
            rxn_q   <= '0;
            bank_q  <= '0;
            start_q <= 1'b0;
            xtx_q   <= '0;
            xrx_q   <= '0;
            xword_q <= '0;
            xop_q   <= XOP_NONE;
        end else begin
            start_q <= 1'b0;
            if (wr_cmd && cmd_open) begin
                txn_q  <= bus_wdata[F_TXN +: 3];
                rxn_q  <= bus_wdata[F_RXN +: 3];
                bank_q <= bus_wdata[F_BANK +: 2];
                if (bus_wdata[B_RDSR]) begin
                    start_q <= 1'b1;
                    xop_q   <= XOP_RDSR;
                    xtx_q   <= 3'd1;
                    xrx_q   <= 3'd1;
                    xword_q <= DATA_W'(OPC_RDSR);
                end else if (bus_wdata[B_WREN]) begin
                    start_q <= 1'b1;
                    xop_q   <= XOP_WREN;
                    xtx_q   <= 3'd1;
                    xrx_q   <= 3'd0;
                    xword_q <= DATA_W'(OPC_WREN);
                end else if (bus_wdata[B_GO] && swcmd_q) begin
                    start_q <= 1'b1;
                    xop_q   <= XOP_SEND;
                    xtx_q   <= clamp_cnt(bus_wdata[F_TXN +: 3], 3'd1, MAXB);
                    xrx_q   <= clamp_cnt(bus_wdata[F_RXN +: 3], 3'd0, MAXB);
                    xword_q <= txd_q;
                end
            end
        end
    end

    // Completion flag: set by the engine, cleared by a zero in its bit
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else if (eng_done_i) done_q <= 1'b1;
        else if (wr_stat && !bus_wdata[B_DONE]) done_q <= 1'b0;
    end

    // Result capture: status byte for status reads, receive word for sends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fstat_q <= '0;
            rxd_q   <= '0;
        end else if (eng_done_i) begin
            if (xop_q == XOP_RDSR) fstat_q <= eng_rx_i[7:0];
            if (xop_q == XOP_SEND) rxd_q   <= eng_rx_i;
        end
    end

    assign cmd_view_o = {2'b00, bank_q, 5'b0, rxn_q, 1'b0, txn_q};

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_MODE): begin
                bus_rdata[B_SWCMD] = swcmd_q;
                bus_rdata[B_BURST] = burst_q;
            end
            ADDR_W'(OFS_CMD):  bus_rdata[15:0] = cmd_view_o;
            ADDR_W'(OFS_STAT): begin
                bus_rdata[7:0]    = fstat_q;
                bus_rdata[B_DONE] = done_q;
            end
            ADDR_W'(OFS_TXD):  bus_rdata = txd_q;
            ADDR_W'(OFS_RXD):  bus_rdata = rxd_q;
            default:           bus_rdata = '0;
        endcase
    end

    assign start_o     = start_q;
    assign tx_bytes_o  = xtx_q;
    assign rx_bytes_o  = xrx_q;
    assign tx_word_o   = xword_q;
    assign bank_o      = bank_q;
    assign done_flag_o = done_q;

endmodule

// File: rtl/sfc_engine.sv
// Module sfc_engine: mode-3 bit shifter. On start it drops the clock and
// launches bit 0, then runs CLK_DIV system clocks per bit (low half, high
// half), samples the input as the clock rises during the receive phase, and
// spends one tail cycle before releasing select. Assumes CLK_DIV is even,
// at least 2, and that byte counts never exceed DATA_W/8.
module sfc_engine #(
    parameter int DATA_W  = 32,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        tx_bytes_i,
    input  logic [2:0]        rx_bytes_i,
    input  logic [DATA_W-1:0] tx_word_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam int HALF   = CLK_DIV / 2;
    localparam int DIV_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int WIDX_W = $clog2(DATA_W);
    localparam int BIT_W  = WIDX_W + 1;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} st_e;

    st_e               st_q;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q, txbits_q, last_q, nxt_bit;
    logic [DATA_W-1:0] txw_q, rxw_q;
    logic              sck_q, mosi_q;
    logic [BIT_W:0]    tot_bits;

    // Word position of serial bit i: byte i/8, most significant bit first
    function automatic logic [WIDX_W-1:0] wpos(input logic [BIT_W-1:0] i);
        return {i[WIDX_W-1:3], ~i[2:0]};
    endfunction

    assign tot_bits = ((BIT_W+1)'(tx_bytes_i) + (BIT_W+1)'(rx_bytes_i)) << 3;
    assign nxt_bit  = bit_q + 1'b1;

    // Sequencer: clock divider, bit counter, launch and capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            div_q    <= '0;
            bit_q    <= '0;
            txbits_q <= '0;
            last_q   <= '0;
            txw_q    <= '0;
            rxw_q    <= '0;
            sck_q    <= 1'b1;
            mosi_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q     <= ST_RUN;
                        div_q    <= '0;
                        bit_q    <= '0;
                        txbits_q <= BIT_W'({tx_bytes_i, 3'b000});
                        last_q   <= BIT_W'(tot_bits - 1'b1);
                        txw_q    <= tx_word_i;
                        rxw_q    <= '0;
                        sck_q    <= 1'b0;
                        mosi_q   <= tx_word_i[wpos('0)];
                    end
                end
                ST_RUN: begin
                    div_q <= div_q + 1'b1;
                    if (div_q == DIV_W'(HALF - 1)) begin
                        sck_q <= 1'b1;
                        if (bit_q >= txbits_q)
                            rxw_q[wpos(bit_q - txbits_q)] <= miso_i;
                    end
                    if (div_q == DIV_W'(CLK_DIV - 1)) begin
                        div_q <= '0;
                        if (bit_q == last_q) begin
                            st_q <= ST_TAIL;
                        end else begin
                            bit_q  <= nxt_bit;
                            sck_q  <= 1'b0;
                            mosi_q <= (nxt_bit < txbits_q) ? txw_q[wpos(nxt_bit)] : 1'b0;
                        end
                    end
                end
                ST_TAIL: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o    = (st_q != ST_IDLE);
    assign done_o    = (st_q == ST_TAIL);
    assign rx_word_o = rxw_q;
    assign sck_o     = sck_q;
    assign mosi_o    = mosi_q;

endmodule

// File: rtl/sfc_csdec.sv
// Module sfc_csdec: turns the engine's active flag and the bank number into
// one active-low select per bank. Assumes NUM_BANKS is at most 4.
module sfc_csdec #(
    parameter int NUM_BANKS = 4
) (
    input  logic                 active_i,
    input  logic [1:0]           bank_i,
    output logic [NUM_BANKS-1:0] cs_n_o
);
    // One decoder leg per bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_leg
        assign cs_n_o[b] = !(active_i && (bank_i == 2'(b)));
    end
endmodule

// File: rtl/sflash_cmd_master.sv
// Module sflash_cmd_master: top of the serial flash command master. Joins the
// register file, the bit engine and the select decoder. Assumes a single
// clock domain and a flash that works in clock mode 3.
module sflash_cmd_master #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int NUM_BANKS = 4,
    parameter int CLK_DIV   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 spi_sck,
    output logic                 spi_mosi,
    input  logic                 spi_miso,
    output logic [NUM_BANKS-1:0] spi_cs_n
);
    logic              start_w, busy_w, done_w, done_flag_w;
    logic [2:0]        txb_w, rxb_w;
    logic [DATA_W-1:0] txw_w, rxw_w;
    logic [1:0]        bank_w;
    logic [15:0]       cmd_view_w;

    sfc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .eng_busy_i  (busy_w),
        .eng_done_i  (done_w),
        .eng_rx_i    (rxw_w),
        .start_o     (start_w),
        .tx_bytes_o  (txb_w),
        .rx_bytes_o  (rxb_w),
        .tx_word_o   (txw_w),
        .bank_o      (bank_w),
        .done_flag_o (done_flag_w),
        .cmd_view_o  (cmd_view_w)
    );

    sfc_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_w),
        .tx_bytes_i (txb_w),
        .rx_bytes_i (rxb_w),
        .tx_word_i  (txw_w),
        .busy_o     (busy_w),
        .done_o     (done_w),
        .rx_word_o  (rxw_w),
        .sck_o      (spi_sck),
        .mosi_o     (spi_mosi),
        .miso_i     (spi_miso)
    );

    sfc_csdec #(.NUM_BANKS(NUM_BANKS)) u_csdec (
        .active_i (busy_w),
        .bank_i   (bank_w),
        .cs_n_o   (spi_cs_n)
    );

endmodule

// File: rtl/sfc_checker.sv
// Module sfc_checker: protocol properties of the serial flash command master,
// bound to every instance of the top module.
module sfc_checker #(
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sck,
    input logic                 mosi,
    input logic [NUM_BANKS-1:0] cs_n,
    input logic                 done_flag,
    input logic [15:0]          cmd_view
);
    AST_SELECT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)) else $error("more than one select low"); // R10

    AST_CLOCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> sck) else $error("clock low while deselected"); // R2

    AST_CLOCK_FALL_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |-> !(&cs_n)) else $error("clock fell while deselected"); // R2

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $fell(sck)) else $error("data moved off a falling edge"); // R2

    AST_FLAG_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&cs_n) |-> done_flag) else $error("flag not set at release"); // R11

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |=> $stable(cmd_view)) else $error("command word changed in transfer"); // R12
endmodule

bind sflash_cmd_master sfc_checker #(.NUM_BANKS(NUM_BANKS)) u_sfc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .cs_n      (spi_cs_n),
    .done_flag (done_flag_w),
    .cmd_view  (cmd_view_w)
);

// File: tb/sflash_cmd_master_bench.sv
module sflash_cmd_master_bench;
    localparam logic [4:0] A_MODE = 5'h00, A_CMD = 5'h04, A_STAT = 5'h08,
                           A_TXD = 5'h0C, A_RXD = 5'h10;

    // {command word, transmit word, flash response}
    localparam int NVEC = 6;
    localparam logic [79:0] VECS [NVEC] = '{
        {16'h00B1, 32'h0000009F, 32'h00C22017},
        {16'h1084, 32'h563412D8, 32'h00000000},
        {16'h20A2, 32'h0000A5C3, 32'hFFEE5A3C},
        {16'h30D7, 32'h89ABCDEF, 32'h13579BDF},
        {16'h0090, 32'h00000081, 32'h000000E6},
        {16'h30C3, 32'h00ABCDEF, 32'hDEADBEEF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = 5'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi;
    logic        spi_miso = 1'b1;
    logic [3:0]  spi_cs_n;

    always #2 clk = ~clk;

    sflash_cmd_master u_sflash_cmd_master (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int n_vec = 0;
    int n_bad = 0;

    // Flash model: drives response bits after the transmit phase, records data
    int          sl_fall = 0, sl_rise = 0, sl_txb = 1;
    logic [31:0] sl_resp = '0;
    logic [63:0] sl_cap = '0;
    logic [3:0]  sl_cs = '1;

    always @(negedge spi_sck) begin
        int j;
        if (sl_fall >= sl_txb * 8) begin
            j = sl_fall - sl_txb * 8;
            if (j < 32) spi_miso = sl_resp[(j / 8) * 8 + 7 - (j % 8)];
        end
        sl_fall++;
    end

    always @(posedge spi_sck) begin
        sl_cap = {sl_cap[62:0], spi_mosi};
        sl_rise++;
        sl_cs = spi_cs_n;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic arm_slave(input int txb, input logic [31:0] resp);
        sl_fall = 0; sl_rise = 0; sl_cap = '0; sl_txb = txb; sl_resp = resp; sl_cs = '1;
    endtask

    // Wait for select release; the flag must rise exactly there (R11)
    task automatic wait_done(input string req);
        bit prev_act, prev_flag;
        prev_act = 1'b0; prev_flag = 1'b0;
        bus_addr = A_STAT;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            #1;
            if (prev_act && (&spi_cs_n)) begin
                check(bus_rdata[8] == 1'b1 && prev_flag == 1'b0, "R11 flag at release",
                      {prev_flag, bus_rdata[8]}, 2'b01);
                return;
            end
            prev_act  = !(&spi_cs_n);
            prev_flag = bus_rdata[8];
        end
        check(1'b0, req, 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] last_rx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check(spi_sck == 1'b1 && spi_cs_n == 4'hF && spi_mosi == 1'b0, "R1 pins",
              {spi_sck, spi_cs_n, spi_mosi}, 6'b1_1111_0);
        bus_read(A_MODE, rd); check(rd == 0, "R1 mode", rd, 0);
        bus_read(A_CMD, rd);  check(rd == 0, "R1 cmd", rd, 0);
        bus_read(A_STAT, rd); check(rd == 0, "R1 stat", rd, 0);
        bus_read(A_TXD, rd);  check(rd == 0, "R1 txd", rd, 0);
        bus_read(A_RXD, rd);  check(rd == 0, "R1 rxd", rd, 0);

        // R5: go bit ignored without software command mode
        arm_slave(1, 32'h55);
        bus_write(A_TXD, 32'h9F);
        bus_write(A_CMD, 32'h00B1);
        repeat (80) @(negedge clk);
        check(sl_rise == 0, "R5 no clock", sl_rise, 0);
        bus_read(A_STAT, rd); check(rd[8] == 1'b0, "R5 flag clear", rd[8], 0);
        bus_read(A_RXD, rd);  check(rd == 0, "R5 rx unchanged", rd, 0);

        // R6: mode word storage
        bus_write(A_MODE, 32'hFFFF_FFFF);
        bus_read(A_MODE, rd); check(rd == 32'h3000_0000, "R6 readback", rd, 32'h3000_0000);
        bus_write(A_MODE, 32'h1000_0000);
        bus_read(A_MODE, rd); check(rd == 32'h1000_0000, "R6 burst off", rd, 32'h1000_0000);

        // Table walk: R2, R3, R4, R10, R12 readback
        last_rx = '0;
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] c2;
            logic [31:0] tw, rs, exp_rx;
            int etx, erx, bank, nb, mis_tx, mis_rx;
            bit expb;
            c2 = VECS[v][79:64]; tw = VECS[v][63:32]; rs = VECS[v][31:0];
            etx = int'(c2[2:0]); if (etx == 0) etx = 1; if (etx > 4) etx = 4;
            erx = int'(c2[6:4]); if (erx > 4) erx = 4;
            bank = int'(c2[13:12]);
            nb = (etx + erx) * 8;
            bus_write(A_TXD, tw);
            bus_write(A_STAT, 32'h0);
            arm_slave(etx, rs);
            bus_write(A_CMD, {16'h0, c2});
            wait_done("R2 transfer completes");
            check(sl_rise == nb, "R2 edge count", sl_rise, nb);
            mis_tx = 0; mis_rx = 0;
            for (int i = 0; i < nb; i++) begin
                expb = (i < etx * 8) ? tw[(i / 8) * 8 + 7 - (i % 8)] : 1'b0;
                if (sl_cap[nb - 1 - i] != expb) begin
                    if (i < etx * 8) mis_tx++; else mis_rx++;
                end
            end
            check(mis_tx == 0, "R3 transmit order", mis_tx, 0);
            check(mis_rx == 0, "R4 output low while receiving", mis_rx, 0);
            check(sl_cs == ~(4'b1 << bank), "R10 bank select", sl_cs, ~(4'b1 << bank));
            exp_rx = (erx == 4) ? rs : (rs & ((32'h1 << (erx * 8)) - 1));
            bus_read(A_RXD, rd); check(rd == exp_rx, "R4 receive packing", rd, exp_rx);
            bus_read(A_CMD, rd); check(rd == {16'h0, c2 & 16'h3077}, "R12 field readback", rd, c2 & 16'h3077);
            last_rx = exp_rx;
        end

        // R7: status read shortcut on bank 2
        bus_write(A_STAT, 32'h0);
        arm_slave(1, 32'hA7);
        bus_write(A_CMD, 32'h2400);
        wait_done("R7 completes");
        check(sl_rise == 16 && sl_cap[15:0] == 16'h0500, "R7 opcode 05", {sl_rise[7:0], sl_cap[15:0]}, 24'h10_0500);
        check(sl_cs == 4'b1011, "R10 status read bank", sl_cs, 4'b1011);
        bus_read(A_STAT, rd); check(rd == 32'h1A7, "R7 status byte", rd, 32'h1A7);
        bus_read(A_RXD, rd);  check(rd == last_rx, "R7 rx unchanged", rd, last_rx);

        // R8: write-enable shortcut
        bus_write(A_STAT, 32'h0);
        arm_slave(1, 32'h0);
        bus_write(A_CMD, 32'h0800);
        wait_done("R8 completes");
        check(sl_rise == 8 && sl_cap[7:0] == 8'h06, "R8 opcode 06", {sl_rise[7:0], sl_cap[7:0]}, 16'h0806);
        bus_read(A_STAT, rd); check(rd == 32'h1A7, "R8 status byte kept", rd, 32'h1A7);

        // R9: priority among trigger bits
        bus_write(A_STAT, 32'h0);
        arm_slave(1, 32'h3C);
        bus_write(A_CMD, 32'h0C80);
        wait_done("R9 completes");
        check(sl_rise == 16 && sl_cap[15:0] == 16'h0500, "R9 status read wins", {sl_rise[7:0], sl_cap[15:0]}, 24'h10_0500);
        bus_read(A_STAT, rd); check(rd == 32'h13C, "R9 status byte", rd, 32'h13C);
        bus_write(A_STAT, 32'h0);
        arm_slave(1, 32'h0);
        bus_write(A_CMD, 32'h0880);
        wait_done("R9 second completes");
        check(sl_rise == 8 && sl_cap[7:0] == 8'h06, "R9 write enable wins", {sl_rise[7:0], sl_cap[7:0]}, 16'h0806);

        // R11: write-one leaves the flag, write-zero clears it
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_read(A_STAT, rd); check(rd[8] == 1'b1, "R11 write one keeps", rd[8], 1);
        bus_write(A_STAT, 32'hFFFF_FEFF);
        bus_read(A_STAT, rd); check(rd[8] == 1'b0, "R11 write zero clears", rd[8], 0);

        // R12: command write in mid-transfer is ignored
        bus_write(A_TXD, 32'h9F);
        arm_slave(1, 32'h00112233);
        bus_write(A_CMD, 32'h10B1);
        repeat (20) @(negedge clk);
        bus_write(A_CMD, 32'h3082);
        wait_done("R12 completes");
        bus_read(A_CMD, rd); check(rd == 32'h1031, "R12 fields kept", rd, 32'h1031);
        check(sl_cs == 4'b1101, "R12 bank kept", sl_cs, 4'b1101);
        repeat (100) @(negedge clk);
        check(sl_rise == 32, "R12 no second transfer", sl_rise, 32);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule